// File: doc/BRIEF.md
# Directory Coherence Controller

This block keeps the coherence record for a small set of memory blocks shared by four caches. Each block has an entry with a state (Invalid, Shared or Modified) and a presence mask with one bit per cache. The caches send read, write and upgrade requests through one request port, with one valid/ready pair per cache. The directory answers on a single message stream. It sends grants to requesters, multicast invalidates to sharers and forwards to the current owner. It also collects acknowledgements and owner data, and it signals a memory writeback when modified data moves to the Shared state.

Only one transaction is in flight at a time. It runs through a short sequence: accept, optional invalidate or forward, wait, grant. Among requests arriving in the same cycle, the lowest cache index wins. While a transaction is pending, a request that targets the same block is accepted at once with a retry indication. A request that targets a different block is held with ready low until the engine is idle again. The message port follows valid/ready rules: once `msg_valid` is high, the message fields stay frozen until `msg_ready` is seen at a clock edge. The entry table is updated only in the cycle in which the final grant is taken.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset every entry is Invalid with an empty presence mask, no message is offered and no writeback is signalled.
- R2: A read (op 0) to an Invalid or Shared block is answered with exactly one GRANT_S message (type 1) addressed to the requester, carrying zero data. The requester joins the presence mask and the entry becomes Shared.
- R3: A write (op 1), upgrade (op 2) or op 3 to a Shared block that has sharers other than the requester first sends one INV message (type 3) whose destination mask holds exactly those other sharers. GRANT_M (type 2) to the requester follows only after every one of them has acknowledged, and acknowledgements from caches outside that mask have no effect. The entry becomes Modified with the requester as sole owner.
- R4: A write-class request to an Invalid block, or to a Shared block whose only sharer is the requester, is answered directly with GRANT_M and no INV.
- R5: A write-class request to a block Modified by another cache sends FWD_WR (type 5) to the owner. After the owner returns data, GRANT_M carrying that data goes to the requester, no writeback is signalled, and the requester becomes sole owner.
- R6: A read to a block Modified by another cache sends FWD_RD (type 4) to the owner. The cycle after the owner's data is taken, `mem_wb_valid` pulses for one cycle with that block and data, and GRANT_S with the data goes to the requester. The entry becomes Shared with the old owner and the requester present.
- R7: Any request from the cache that currently holds the block Modified is answered with a single HIT message (type 6) and leaves the entry unchanged.
- R8: A data return from a cache that is not the owner being waited on is ignored.
- R9: While a transaction is pending, a request to the same block gets ready and retry in the same cycle and has no effect; a request to another block sees ready low.
- R10: Among requests that arrive in the same cycle while idle, only the lowest-indexed cache is accepted.
- R11: While `msg_valid` is high and `msg_ready` is low, the message stays valid with all its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NC | Request valid, one bit per cache |
| req_op | input | 2*NC | Request op per cache: 0 read, 1 write, 2 upgrade, 3 write |
| req_blk | input | BW*NC | Target block index per cache |
| req_ready | output | NC | Request taken this cycle |
| req_retry | output | NC | With req_ready: request bounced as busy |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_type | output | 3 | 1 GRANT_S, 2 GRANT_M, 3 INV, 4 FWD_RD, 5 FWD_WR, 6 HIT |
| msg_dst | output | NC | Destination cache mask |
| msg_blk | output | BW | Block index of the message |
| msg_data | output | DW | Forwarded data on grants, zero otherwise |
| ack_valid | input | NC | Invalidate acknowledgement pulses per cache |
| dret_valid | input | 1 | Owner data return valid |
| dret_src | input | CW | Cache returning data |
| dret_data | input | DW | Returned data |
| mem_wb_valid | output | 1 | One-cycle memory writeback pulse |
| mem_wb_blk | output | BW | Writeback block index |
| mem_wb_data | output | DW | Writeback data |

## Verification
The bench goes after the wait states. It sends a stray acknowledgement from the requester while invalidates are outstanding; a design that counted any acknowledgement would grant early. It returns data from a non-owner while a forward is pending; a design that did not check the source would relay wrong data. It also raises same-block and other-block requests mid-transaction; getting this wrong would show up as a missing retry or as a second accepted request that corrupts the entry. The requester set is swept against all entry states, including an owner re-requesting its own block (which would wrongly trigger a forward) and an upgrade from the sole sharer (which would send an empty invalidate). Back-pressure stalls on the message port check that nothing commits or changes before the handshake.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } dstate_e;

  typedef enum logic [2:0] {
    MSG_NONE    = 3'd0,
    MSG_GRANT_S = 3'd1,
    MSG_GRANT_M = 3'd2,
    MSG_INV     = 3'd3,
    MSG_FWD_RD  = 3'd4,
    MSG_FWD_WR  = 3'd5,
    MSG_HIT     = 3'd6
  } msg_e;

  localparam logic [1:0] OP_READ = 2'd0;

endpackage

// File: rtl/dir_arbiter.sv
module dir_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  // fixed priority: lower index wins
  for (genvar i = 0; i < N; i++) begin : gen_pri
    if (i == 0) begin : gen_first
      assign grant[i] = req[i];
    end else begin : gen_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

endmodule

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NB = 4,
  parameter int NC = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_blk,
  output dstate_e       rd_st,
  output logic [NC-1:0] rd_pres,
  input  logic          we,
  input  logic [BW-1:0] wr_blk,
  input  dstate_e       wr_st,
  input  logic [NC-1:0] wr_pres
);

  dstate_e       st_w [NB];
  logic [NC-1:0] pr_w [NB];

  for (genvar g = 0; g < NB; g++) begin : gen_ent
    dstate_e       st_r;
    logic [NC-1:0] pr_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_r <= ST_I;
        pr_r <= '0;
      end else if (we && wr_blk == BW'(g)) begin
        st_r <= wr_st;
        pr_r <= wr_pres;
      end
    end

    assign st_w[g] = st_r;
    assign pr_w[g] = pr_r;

    AST_M_SOLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      st_r == ST_M |-> $countones(pr_r) == 1); // R5
    AST_I_NO_SHARERS: assert property (@(posedge clk) disable iff (!rst_n)
      st_r == ST_I |-> pr_r == '0); // R1
    AST_S_HAS_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
      st_r == ST_S |-> pr_r != '0); // R2
  end

  assign rd_st   = st_w[rd_blk];
  assign rd_pres = pr_w[rd_blk];

endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import dir_pkg::*;
#(
  parameter int NB = 4,
  parameter int NC = 4,
  parameter int DW = 16,
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [CW-1:0] acc_c,
  input  logic [1:0]    acc_op,
  input  logic [BW-1:0] acc_blk,
  input  dstate_e       ent_st,
  input  logic [NC-1:0] ent_pres,
  input  logic          msg_ready,
  input  logic [NC-1:0] ack_valid,
  input  logic          dret_valid,
  input  logic [CW-1:0] dret_src,
  input  logic [DW-1:0] dret_data,
  output logic          busy,
  output logic [BW-1:0] busy_blk,
  output logic          msg_valid,
  output logic [2:0]    msg_type,
  output logic [NC-1:0] msg_dst,
  output logic [BW-1:0] msg_blk,
  output logic [DW-1:0] msg_data,
  output logic          mem_wb_valid,
  output logic [BW-1:0] mem_wb_blk,
  output logic [DW-1:0] mem_wb_data,
  output logic          tbl_we,
  output logic [BW-1:0] tbl_blk,
  output dstate_e       tbl_st,
  output logic [NC-1:0] tbl_pres
);

  typedef enum logic [2:0] {
    E_IDLE, E_INV, E_ACK, E_FWD, E_DATA, E_GRANT
  } est_e;

  est_e          st_q;
  logic [CW-1:0] rc_q;
  logic          rd_q;
  logic [BW-1:0] blk_q;
  logic [NC-1:0] pend_q;
  logic [NC-1:0] cur_q;
  logic [DW-1:0] data_q;
  msg_e          gt_q;
  logic          wb_q;

  logic [NC-1:0] acc_bit, rq_bit, others, pend_left;
  logic          is_rd, own;
  msg_e          mt;

  assign acc_bit   = NC'(1) << acc_c;
  assign rq_bit    = NC'(1) << rc_q;
  assign is_rd     = (acc_op == OP_READ);
  assign own       = (ent_st == ST_M) && ent_pres[acc_c];
  assign others    = ent_pres & ~acc_bit;
  assign pend_left = pend_q & ~ack_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      rc_q   <= '0;
      rd_q   <= 1'b0;
      blk_q  <= '0;
      pend_q <= '0;
      cur_q  <= '0;
      data_q <= '0;
      gt_q   <= MSG_NONE;
      wb_q   <= 1'b0;
    end else begin
      wb_q <= 1'b0;
      case (st_q)
        E_IDLE: begin
          if (acc) begin
            rc_q   <= acc_c;
            rd_q   <= is_rd;
            blk_q  <= acc_blk;
            cur_q  <= ent_pres;
            data_q <= '0;
            pend_q <= '0;
            if (own) begin
              gt_q <= MSG_HIT;
              st_q <= E_GRANT;
            end else if (ent_st == ST_M) begin
              gt_q <= is_rd ? MSG_GRANT_S : MSG_GRANT_M;
              st_q <= E_FWD;
            end else if (is_rd) begin
              gt_q <= MSG_GRANT_S;
              st_q <= E_GRANT;
            end else if (|others) begin
              gt_q   <= MSG_GRANT_M;
              pend_q <= others;
              st_q   <= E_INV;
            end else begin
              gt_q <= MSG_GRANT_M;
              st_q <= E_GRANT;
            end
          end
        end
        E_INV: if (msg_ready) st_q <= E_ACK;
        E_ACK: begin
          pend_q <= pend_left;
          if (pend_left == '0) st_q <= E_GRANT;
        end
        E_FWD: if (msg_ready) st_q <= E_DATA;
        E_DATA: begin
          if (dret_valid && cur_q[dret_src]) begin
            data_q <= dret_data;
            wb_q   <= rd_q;
            st_q   <= E_GRANT;
          end
        end
        E_GRANT: if (msg_ready) st_q <= E_IDLE;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    mt      = MSG_NONE;
    msg_dst = '0;
    case (st_q)
      E_INV: begin
        mt      = MSG_INV;
        msg_dst = pend_q;
      end
      E_FWD: begin
        mt      = rd_q ? MSG_FWD_RD : MSG_FWD_WR;
        msg_dst = cur_q;
      end
      E_GRANT: begin
        mt      = gt_q;
        msg_dst = rq_bit;
      end
      default: begin
        mt      = MSG_NONE;
        msg_dst = '0;
      end
    endcase
  end

  assign busy      = (st_q != E_IDLE);
  assign busy_blk  = blk_q;
  assign msg_valid = (st_q == E_INV) || (st_q == E_FWD) || (st_q == E_GRANT);
  assign msg_type  = mt;
  assign msg_blk   = blk_q;
  assign msg_data  = (st_q == E_GRANT) ? data_q : '0;

  assign mem_wb_valid = wb_q;
  assign mem_wb_blk   = blk_q;
  assign mem_wb_data  = data_q;

  assign tbl_we   = (st_q == E_GRANT) && msg_ready && (gt_q != MSG_HIT);
  assign tbl_blk  = blk_q;
  assign tbl_st   = (gt_q == MSG_GRANT_S) ? ST_S : ST_M;
  assign tbl_pres = (gt_q == MSG_GRANT_S) ? (cur_q | rq_bit) : rq_bit;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) && $stable(msg_dst)
      && $stable(msg_blk) && $stable(msg_data)); // R11
  AST_GRANT_M_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == MSG_GRANT_M |-> pend_q == '0); // R3
  AST_INV_OTHERS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == MSG_INV |-> (msg_dst & rq_bit) == '0 && msg_dst != '0); // R3
  AST_WB_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> $past(dret_valid) && $past(st_q == E_DATA)); // R6
  AST_ACC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> st_q == E_IDLE); // R9

endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl
  import dir_pkg::*;
#(
  parameter int NC = 4,
  parameter int NB = 4,
  parameter int DW = 16,
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(NC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    req_valid,
  input  logic [NC*2-1:0]  req_op,
  input  logic [NC*BW-1:0] req_blk,
  output logic [NC-1:0]    req_ready,
  output logic [NC-1:0]    req_retry,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [2:0]       msg_type,
  output logic [NC-1:0]    msg_dst,
  output logic [BW-1:0]    msg_blk,
  output logic [DW-1:0]    msg_data,
  input  logic [NC-1:0]    ack_valid,
  input  logic             dret_valid,
  input  logic [CW-1:0]    dret_src,
  input  logic [DW-1:0]    dret_data,
  output logic             mem_wb_valid,
  output logic [BW-1:0]    mem_wb_blk,
  output logic [DW-1:0]    mem_wb_data
);

  logic          busy;
  logic [BW-1:0] busy_blk;
  logic [NC-1:0] grant, same_blk;
  logic [CW-1:0] win_c;
  logic [1:0]    win_op;
  logic [BW-1:0] win_blk;
  logic          acc;
  dstate_e       ent_st, tbl_st;
  logic [NC-1:0] ent_pres, tbl_pres;
  logic          tbl_we;
  logic [BW-1:0] tbl_blk;

  dir_arbiter #(.N(NC)) u_arb (
    .req   (req_valid & ~{NC{busy}}),
    .grant (grant)
  );

  for (genvar i = 0; i < NC; i++) begin : gen_cmp
    assign same_blk[i] = req_valid[i] && (req_blk[i*BW +: BW] == busy_blk);
  end

  always_comb begin
    win_c   = '0;
    win_op  = '0;
    win_blk = '0;
    for (int i = 0; i < NC; i++) begin
      if (grant[i]) begin
        win_c   = CW'(i);
        win_op  = req_op[i*2 +: 2];
        win_blk = req_blk[i*BW +: BW];
      end
    end
  end

  assign acc       = |grant;
  assign req_ready = busy ? same_blk : grant;
  assign req_retry = busy ? same_blk : '0;

  dir_table #(.NB(NB), .NC(NC)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_blk  (win_blk),
    .rd_st   (ent_st),
    .rd_pres (ent_pres),
    .we      (tbl_we),
    .wr_blk  (tbl_blk),
    .wr_st   (tbl_st),
    .wr_pres (tbl_pres)
  );

  dir_engine #(.NB(NB), .NC(NC), .DW(DW)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .acc_c        (win_c),
    .acc_op       (win_op),
    .acc_blk      (win_blk),
    .ent_st       (ent_st),
    .ent_pres     (ent_pres),
    .msg_ready    (msg_ready),
    .ack_valid    (ack_valid),
    .dret_valid   (dret_valid),
    .dret_src     (dret_src),
    .dret_data    (dret_data),
    .busy         (busy),
    .busy_blk     (busy_blk),
    .msg_valid    (msg_valid),
    .msg_type     (msg_type),
    .msg_dst      (msg_dst),
    .msg_blk      (msg_blk),
    .msg_data     (msg_data),
    .mem_wb_valid (mem_wb_valid),
    .mem_wb_blk   (mem_wb_blk),
    .mem_wb_data  (mem_wb_data),
    .tbl_we       (tbl_we),
    .tbl_blk      (tbl_blk),
    .tbl_st       (tbl_st),
    .tbl_pres     (tbl_pres)
  );

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready & ~req_retry)); // R10
  AST_RETRY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_retry != '0 |-> msg_valid || !$stable(msg_valid) || busy); // R9

endmodule

// File: tb/dir_coh_ctrl_tb.sv
module dir_coh_ctrl_tb;
  localparam int NC = 4;
  localparam int NB = 4;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam int CW = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC*2-1:0]  req_op = '0;
  logic [NC*BW-1:0] req_blk = '0;
  logic [NC-1:0]    req_ready, req_retry;
  logic             msg_valid;
  logic             msg_ready = 1'b1;
  logic [2:0]       msg_type;
  logic [NC-1:0]    msg_dst;
  logic [BW-1:0]    msg_blk;
  logic [DW-1:0]    msg_data;
  logic [NC-1:0]    ack_valid = '0;
  logic             dret_valid = 1'b0;
  logic [CW-1:0]    dret_src = '0;
  logic [DW-1:0]    dret_data = '0;
  logic             mem_wb_valid;
  logic [BW-1:0]    mem_wb_blk;
  logic [DW-1:0]    mem_wb_data;

  always #10 clk = ~clk;

  dir_coh_ctrl #(.NC(NC), .NB(NB), .DW(DW)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  int mst [NB];
  logic [NC-1:0] mpr [NB];
  logic [DW-1:0] dseed = 16'h1234;
  logic [31:0]   lcg = 32'h2468ace1;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_req(int c, int op, int b, bit v);
    req_valid[c]          = v;
    req_op[c*2 +: 2]      = 2'(op);
    req_blk[c*BW +: BW]   = BW'(b);
  endtask

  task automatic get_msg(string tag, int typ, logic [NC-1:0] dst, int b,
                         logic [DW-1:0] d, int stall);
    int n = 0;
    while (!msg_valid && n < 20) begin tick(); n++; end
    chk({tag, " valid"}, msg_valid, 1);
    chk({tag, " type"}, msg_type, typ);
    chk({tag, " dst"}, msg_dst, dst);
    chk({tag, " blk"}, msg_blk, b);
    chk({tag, " data"}, msg_data, d);
    if (stall > 0) begin
      msg_ready = 1'b0;
      repeat (stall) tick();
      chk("R11 held valid", msg_valid, 1);
      chk("R11 held type", msg_type, typ);
      chk("R11 held dst", msg_dst, dst);
      msg_ready = 1'b1;
    end
    tick();
  endtask

  task automatic poke_wait(int c, int b, bit data_phase);
    if (data_phase) begin
      dret_valid = 1'b1; dret_src = CW'(c); dret_data = 16'hdead;
      tick();
      dret_valid = 1'b0;
      chk("R8 stray data ignored", msg_valid, 0);
    end else begin
      ack_valid = NC'(1) << c;
      tick();
      ack_valid = '0;
      chk("R3 stray ack ignored", msg_valid, 0);
    end
    set_req((c + 1) % NC, 1, b, 1);
    set_req((c + 2) % NC, 0, (b + 1) % NB, 1);
    #1;
    chk("R9 same block ready", req_ready[(c + 1) % NC], 1);
    chk("R9 same block retry", req_retry[(c + 1) % NC], 1);
    chk("R9 other block held", req_ready[(c + 2) % NC], 0);
    tick();
    req_valid = '0;
  endtask

  task automatic txn(int c, int op, int b, int stall, bit inject, logic [NC-1:0] rivals);
    logic [NC-1:0] rb = NC'(1) << c;
    int s = mst[b];
    logic [NC-1:0] p = mpr[b];
    logic [NC-1:0] oth = p & ~rb;
    bit rd = (op == 0);
    int own_i = 0;
    logic [DW-1:0] d;
    dseed = dseed * 16'd5 + 16'd7;
    d = dseed;
    for (int i = 0; i < NC; i++) if (p[i]) own_i = i;
    set_req(c, op, b, 1);
    for (int i = 0; i < NC; i++) if (rivals[i]) set_req(i, 0, (b + 1) % NB, 1);
    #1;
    chk("R10 accept winner", req_ready, rb);
    chk("R10 no retry idle", req_retry, 0);
    tick();
    req_valid = '0;
    if (s == 2 && p == rb) begin
      get_msg("R7 owner hit", 6, rb, b, '0, stall);
    end else if (s == 2) begin
      get_msg(rd ? "R6 fwd rd" : "R5 fwd wr", rd ? 4 : 5, p, b, '0, stall);
      if (inject) poke_wait(c, b, 1'b1);
      dret_valid = 1'b1; dret_src = CW'(own_i); dret_data = d;
      tick();
      dret_valid = 1'b0;
      if (rd) begin
        chk("R6 wb pulse", mem_wb_valid, 1);
        chk("R6 wb blk", mem_wb_blk, b);
        chk("R6 wb data", mem_wb_data, d);
        get_msg("R6 grant shared", 1, rb, b, d, 0);
        chk("R6 wb single", mem_wb_valid, 0);
        mst[b] = 1; mpr[b] = p | rb;
      end else begin
        chk("R5 no wb", mem_wb_valid, 0);
        get_msg("R5 grant mod", 2, rb, b, d, 0);
        mst[b] = 2; mpr[b] = rb;
      end
    end else if (rd) begin
      get_msg(s == 0 ? "R1/R2 read fresh" : "R2 read shared", 1, rb, b, '0, stall);
      mst[b] = 1; mpr[b] = p | rb;
    end else if (oth != '0) begin
      get_msg("R3 inv", 3, oth, b, '0, stall);
      if (inject) poke_wait(c, b, 1'b0);
      for (int i = 0; i < NC; i++) begin
        if (oth[i]) begin
          chk("R3 grant waits acks", msg_valid, 0);
          ack_valid = NC'(1) << i;
          tick();
          ack_valid = '0;
        end
      end
      get_msg("R3 grant mod", 2, rb, b, '0, 0);
      mst[b] = 2; mpr[b] = rb;
    end else begin
      get_msg("R4 direct grant", 2, rb, b, '0, stall);
      mst[b] = 2; mpr[b] = rb;
    end
    chk("R7 no extra msg", msg_valid, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mst[b] = 0; mpr[b] = '0; end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset no msg", msg_valid, 0);
    chk("R1 reset no wb", mem_wb_valid, 0);
    chk("R1 reset no ready", req_ready, 0);
    // directed sequence on block 0
    txn(0, 0, 0, 0, 0, '0);
    txn(1, 0, 0, 0, 0, '0);
    txn(1, 2, 0, 1, 1, '0);
    txn(2, 1, 0, 0, 1, '0);
    txn(2, 0, 0, 0, 0, '0);
    txn(3, 0, 0, 2, 1, '0);
    txn(3, 2, 0, 0, 0, '0);
    txn(3, 3, 0, 0, 0, '0);
    // upgrade by sole sharer and fresh write
    txn(1, 0, 1, 0, 0, '0);
    txn(1, 2, 1, 0, 0, '0);
    txn(2, 1, 2, 0, 0, '0);
    // same-cycle competition
    txn(0, 1, 3, 0, 0, 4'b1110);
    txn(1, 0, 3, 0, 0, 4'b1100);
    txn(2, 0, 2, 0, 0, 4'b1000);
    // sweep
    for (int i = 0; i < 320; i++) begin
      int c, op, b;
      logic [NC-1:0] rv;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      c  = int'(lcg[17:16]);
      op = int'(lcg[21:20]);
      b  = int'(lcg[25:24]);
      rv = '0;
      if (i % 3 == 0 && c == 0) rv = 4'b1110;
      if (i % 3 == 0 && c == 1) rv = 4'b1100;
      txn(c, op, b, (i % 7 == 0) ? 2 : 0, (i % 5 == 0), rv);
    end
    finish_run();
  end

endmodule